// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs the management side of a clause-22 serial management link to an Ethernet PHY. It generates the management clock MDC from the system clock and drives the shared bidirectional data line through three signals: an output value, an output enable and a sampled input. Each transfer is either a register read or a register write, addressed by a 5-bit PHY number and a 5-bit register number. The block can optionally send an all-ones preamble before each frame.

A client presents a request with `reqValid` while the block is idle. The block copies the request fields and the preamble flag at that moment and then plays out the whole frame on its own. When the frame has ended, `rdDone` pulses for one clock. After a read, `rdData` holds the 16-bit result until the next read finishes.

The MDC half-period is the parameter `HALF_CYC`, counted in system clocks. The default of 20 gives 2.5 MHz from a 100 MHz clock.

Top module: `mdio_master`

## Requirements
- R1: When no frame is in progress, `mdc` is 0, `mdioOe` is 0 and `busy` is 0. This also holds out of reset.
- R2: Each bit period lasts 2*HALF_CYC clocks: HALF_CYC clocks with `mdc` low, then HALF_CYC clocks with `mdc` high. The driven bit changes only when a low phase begins, so it is held across the rising edge.
- R3: If `preambleEn` is 1 when a request is accepted, 32 bit periods of 1 with `mdioOe` high come before the frame. If it is 0, the frame starts at once.
- R4: A read header is 16 bit periods with `mdioOe` high, sent MSB first: 1,1, then 0,1, then 1,0, then the PHY address, then the register address.
- R5: After a read header, `mdioOe` is low for exactly 20 bit periods. The frame then ends.
- R6: In each of the 20 receive periods, `mdioIn` is sampled on the last clock before MDC rises and shifted in MSB first. The read result is the samples taken in receive periods 4 to 19 (counting from 1), MSB first. The samples from periods 1 to 3 and period 20 are discarded.
- R7: A write frame is 32 bit periods with `mdioOe` high, sent MSB first: 0,1, then 0,1, then the PHY address, the register address, 1,0, and the 16 data bits. Two bit periods with `mdioOe` low follow.
- R8: `rdDone` is high for exactly one clock, in the clock after the last bit period of a read or a write ends, with `busy` already low. `rdData` changes only at the end of a read and keeps its value across writes.
- R9: A request is accepted only while `busy` is 0. Changes on the request inputs or on `preambleEn` during a frame do not affect that frame.
- R10: `mdioOut` is 0 whenever `mdioOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a transfer (taken when idle) |
| reqWrite | input | 1 | 1 = write frame, 0 = read frame |
| reqPhy | input | 5 | PHY address |
| reqReg | input | 5 | Register address |
| reqData | input | 16 | Write data |
| preambleEn | input | 1 | Send 32-bit all-ones preamble first |
| busy | output | 1 | Frame in progress |
| rdDone | output | 1 | One-clock end-of-transfer strobe |
| rdData | output | 16 | Result of the last read |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Line value to drive |
| mdioOe | output | 1 | Line drive enable |
| mdioIn | input | 1 | Sampled line value |

## Verification
The assertions rely on two assumptions about the inputs:
- `mdioIn` is settled at the clock where the receive sample is taken.
- `reqValid` may arrive at any time, and a request that arrives while a frame is running is dropped.

The bench responder changes `mdioIn` only after a rising MDC edge. It counts the rising edges seen while the line is released and puts the next pattern bit on the line, so no change falls near a sampling clock. Mid-frame requests and a toggled preamble flag are applied on purpose. The reference waveform for each frame is built only from the fields present at acceptance.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int FRAME_W  = 32;
  localparam int RX_W     = 20;
  localparam int PRE_BITS = 32;
  localparam int RD_BITS  = 16;
  localparam int WR_BITS  = 32;
  localparam int TAIL_BITS = 2;
  localparam int BIT_W    = $clog2(FRAME_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_HDR,
    ST_RX,
    ST_TAIL
  } mdioState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture request and build frame
    logic shiftTx;   // advance to next header bit
    logic sample;    // take one receive sample
    logic preamble;  // force ones on the line
    logic drive;     // line enable
    logic finishRd;  // read complete, publish result
  } mdioStrb_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_CYC = 20
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      preambleEn,
  output mdioStrb_t strb,
  output logic      mdc,
  output logic      busy,
  output logic      done
);
  localparam int CW = $clog2(2 * HALF_CYC);
  localparam logic [CW-1:0] MID_CNT  = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] HIGH_CNT = CW'(HALF_CYC);
  localparam logic [CW-1:0] LAST_CNT = CW'(2 * HALF_CYC - 1);

  mdioState_e state;
  logic [CW-1:0]    halfCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             isWrite;
  logic [BIT_W-1:0] lastIdx;
  logic             bitEnd;
  logic             stateEnd;
  mdioState_e       nextState;

  always_comb begin
    unique case (state)
      ST_PRE:  lastIdx = BIT_W'(PRE_BITS - 1);
      ST_HDR:  lastIdx = isWrite ? BIT_W'(WR_BITS - 1) : BIT_W'(RD_BITS - 1);
      ST_RX:   lastIdx = BIT_W'(RX_W - 1);
      ST_TAIL: lastIdx = BIT_W'(TAIL_BITS - 1);
      default: lastIdx = '0;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_PRE:  nextState = ST_HDR;
      ST_HDR:  nextState = isWrite ? ST_TAIL : ST_RX;
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign bitEnd   = busy && (halfCnt == LAST_CNT);
  assign stateEnd = bitEnd && (bitCnt == lastIdx);
  assign mdc      = busy && (halfCnt >= HIGH_CNT);

  always_comb begin
    strb          = '0;
    strb.load     = !busy && reqValid;
    strb.shiftTx  = (state == ST_HDR) && bitEnd;
    strb.sample   = (state == ST_RX) && (halfCnt == MID_CNT);
    strb.preamble = (state == ST_PRE);
    strb.drive    = (state == ST_PRE) || (state == ST_HDR);
    strb.finishRd = (state == ST_RX) && stateEnd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      bitCnt  <= '0;
      isWrite <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= stateEnd && ((state == ST_RX) || (state == ST_TAIL));
      if (strb.load) begin
        state   <= preambleEn ? ST_PRE : ST_HDR;
        isWrite <= reqWrite;
        halfCnt <= '0;
        bitCnt  <= '0;
      end else if (busy) begin
        halfCnt <= bitEnd ? '0 : halfCnt + 1'b1;
        if (stateEnd) begin
          bitCnt <= '0;
          state  <= nextState;
        end else if (bitEnd) begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // R2
  mdc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && halfCnt != MID_CNT && halfCnt != LAST_CNT) |=> $stable(mdc));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mdc && !busy));

  // R9
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reqValid));
endmodule

// File: rtl/mdio_dpath.sv
module mdio_dpath
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mdioStrb_t         strb,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqPhy,
  input  logic [ADDR_W-1:0] reqReg,
  input  logic [DATA_W-1:0] reqData,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic [DATA_W-1:0] rdData
);
  logic [FRAME_W-1:0] txShift;
  logic [RX_W-1:0]    rxShift;
  logic [FRAME_W-1:0] rdFrame;
  logic [FRAME_W-1:0] wrFrame;

  // read header left-aligned: 11 01 10 phy reg
  assign rdFrame = {2'b11, 2'b01, 2'b10, reqPhy, reqReg, {(FRAME_W - RD_BITS){1'b0}}};
  // write frame: 01 01 phy reg 10 data
  assign wrFrame = {2'b01, 2'b01, reqPhy, reqReg, 2'b10, reqData};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txShift <= '0;
      rxShift <= '0;
      rdData  <= '0;
    end else begin
      if (strb.load) begin
        txShift <= reqWrite ? wrFrame : rdFrame;
        rxShift <= '0;
      end else begin
        if (strb.shiftTx) txShift <= txShift << 1;
        if (strb.sample)  rxShift <= {rxShift[RX_W-2:0], mdioIn};
      end
      if (strb.finishRd) rdData <= rxShift[DATA_W:1];
    end
  end

  assign mdioOut = strb.drive && (strb.preamble || txShift[FRAME_W-1]);

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.finishRd |=> $stable(rdData));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqPhy,
  input  logic [ADDR_W-1:0] reqReg,
  input  logic [DATA_W-1:0] reqData,
  input  logic              preambleEn,
  output logic              busy,
  output logic              rdDone,
  output logic [DATA_W-1:0] rdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  mdioStrb_t strb;

  mdio_ctrl #(.HALF_CYC(HALF_CYC)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .preambleEn (preambleEn),
    .strb       (strb),
    .mdc        (mdc),
    .busy       (busy),
    .done       (rdDone)
  );

  mdio_dpath i_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .reqWrite (reqWrite),
    .reqPhy   (reqPhy),
    .reqReg   (reqReg),
    .reqData  (reqData),
    .mdioIn   (mdioIn),
    .mdioOut  (mdioOut),
    .rdData   (rdData)
  );

  assign mdioOe = strb.drive;

  // R10
  line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mdioOe |-> !mdioOut);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdioOe));
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
  localparam int H = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [4:0]  reqPhy = '0;
  logic [4:0]  reqReg = '0;
  logic [15:0] reqData = '0;
  logic        preambleEn = 1'b0;
  logic        busy, rdDone, mdc, mdioOut, mdioOe, mdioIn;
  logic [15:0] rdData;

  int checks = 0;
  int fails = 0;
  bit checkOn = 1'b0;

  // expected {mdc, oe, out, busy, done} per clock
  logic [4:0] expQ[$];
  string      tagQ[$];
  logic [15:0] expRd = '0;
  string       expRdTag = "R8";
  logic [4:0]  expNow, actNow;
  string       tagNow;

  // PHY responder
  logic [19:0] pattern = '0;
  int          rxIdx = 0;

  always #5 clk = ~clk;

  mdio_master #(.HALF_CYC(H)) i_mdio_master (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPhy(reqPhy), .reqReg(reqReg), .reqData(reqData), .preambleEn(preambleEn),
    .busy(busy), .rdDone(rdDone), .rdData(rdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always @(posedge mdc) begin
    if (!mdioOe) rxIdx <= rxIdx + 1;
    else         rxIdx <= 0;
  end
  assign mdioIn = (rxIdx < 20) ? pattern[19 - rxIdx] : 1'b0;

  always @(negedge clk) begin
    if (checkOn) begin
      if (expQ.size() > 0) begin
        expNow = expQ.pop_front();
        tagNow = tagQ.pop_front();
      end else begin
        expNow = 5'b00000;
        tagNow = "R1";
      end
      actNow = {mdc, mdioOe, mdioOut, busy, rdDone};
      checks++;
      if (actNow !== expNow) begin
        fails++;
        $display("FAIL %s {mdc,oe,out,busy,done} actual %b expected %b at %0t",
                 tagNow, actNow, expNow, $time);
      end
      if (expNow[0]) begin
        checks++;
        if (rdData !== expRd) begin
          fails++;
          $display("FAIL %s rdData actual %h expected %h", expRdTag, rdData, expRd);
        end
      end
    end
  end

  task automatic pushBit(input logic v, input logic oe, input string tg);
    for (int i = 0; i < H; i++) begin expQ.push_back({1'b0, oe, oe & v, 1'b1, 1'b0}); tagQ.push_back(tg); end
    for (int i = 0; i < H; i++) begin expQ.push_back({1'b1, oe, oe & v, 1'b1, 1'b0}); tagQ.push_back(tg); end
  endtask

  task automatic runFrame(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] dat, input logic pre, input logic [19:0] pat);
    logic [31:0] bits;
    pattern = pat;
    @(negedge clk);
    reqWrite = wr; reqPhy = phy; reqReg = rg; reqData = dat; preambleEn = pre; reqValid = 1'b1;
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    if (pre) for (int i = 0; i < 32; i++) pushBit(1'b1, 1'b1, "R3");
    if (wr) begin
      bits = {2'b01, 2'b01, phy, rg, 2'b10, dat};
      for (int i = 31; i >= 0; i--) pushBit(bits[i], 1'b1, "R7");
      for (int i = 0; i < 2; i++) pushBit(1'b0, 1'b0, "R7");
      expRdTag = "R8";
    end else begin
      bits = {2'b11, 2'b01, 2'b10, phy, rg, 16'h0000};
      for (int i = 31; i >= 16; i--) pushBit(bits[i], 1'b1, "R4");
      for (int i = 0; i < 20; i++) pushBit(1'b0, 1'b0, "R5");
      expRd = pat[16:1];
      expRdTag = "R6";
    end
    expQ.push_back(5'b00001);
    tagQ.push_back("R8");
  endtask

  task automatic waitIdle();
    while (expQ.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    checkOn = 1'b1;
    // R1: reset state
    @(negedge clk);
    checks++;
    if (rdData !== 16'h0000) begin
      fails++;
      $display("FAIL R1 rdData after reset actual %h expected 0000", rdData);
    end
    repeat (3) @(negedge clk);

    // R3 R4 R5 R6: read with preamble, discarded bits set
    runFrame(1'b0, 5'h01, 5'h02, 16'h0, 1'b1, {3'b111, 16'hA5C3, 1'b1});
    waitIdle();
    // R4 R6: read without preamble, discarded bits clear
    runFrame(1'b0, 5'h1F, 5'h00, 16'h0, 1'b0, {3'b000, 16'h8001, 1'b0});
    waitIdle();
    // R6: all-zero data, discarded ones
    runFrame(1'b0, 5'h1F, 5'h1F, 16'h0, 1'b0, {3'b111, 16'h0000, 1'b1});
    waitIdle();
    // R7 R8: writes leave rdData alone
    runFrame(1'b1, 5'h12, 5'h1F, 16'hFFFF, 1'b1, 20'h0);
    waitIdle();
    runFrame(1'b1, 5'h00, 5'h0A, 16'h1234, 1'b0, 20'hFFFFF);
    waitIdle();
    // R9: mid-frame request and flag changes are ignored
    runFrame(1'b0, 5'h0C, 5'h15, 16'h0, 1'b0, {3'b010, 16'h5A3C, 1'b0});
    repeat (300) @(negedge clk);
    reqWrite = 1'b1; reqPhy = 5'h03; reqReg = 5'h07; reqData = 16'hDEAD;
    preambleEn = 1'b1; reqValid = 1'b1;
    repeat (2) @(negedge clk);
    reqValid = 1'b0;
    waitIdle();
    // R9: mid-write changes ignored
    runFrame(1'b1, 5'h15, 5'h0A, 16'hC0DE, 1'b1, 20'h0);
    repeat (1000) @(negedge clk);
    reqPhy = 5'h1F; reqData = 16'h0000; preambleEn = 1'b0; reqWrite = 1'b0;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    waitIdle();

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired, actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule